// File: doc/BRIEF.md
# Ethernet PHY Duplex and Carrier-Sense Control

This block handles duplex for a 10/100 Ethernet physical-layer transceiver. It captures the configuration straps once, in the first clock edge after reset is released. From them it seeds a mode-control register that holds a duplex bit and an auto-negotiation enable bit. The straps also say whether the port runs over fiber. If it does, the duplex bit is seeded from a different strap, and auto-negotiation is held off.

From the duplex bit and three indications from the datapath (transmit active, receive active and raw collision), the block drives the MII carrier-sense and collision outputs. In half duplex, carrier sense covers both directions and collisions are reported. In full duplex, carrier sense shows receive activity only and the collision output stays low.

A second register lets software force each LED output on or off. LEDs that are not forced follow their normal status sources. Software reaches both registers through a plain write strobe, an address and combinational read data. There is no data stream at this block's edge. The register port has no back-pressure: a write is accepted on every cycle in which the strobe is high.

Top module: `phy_dx_ctrl`

## Requirements
- R1: The straps are captured in the first rising clock edge after `rst_n` goes high. Any later change of a strap pin has no effect until the next reset.
- R2: Copper mode (`strap_fx`=0). The auto-negotiation bit (address 0, bit 12) is loaded from `strap_neg_en`. The duplex bit (address 0, bit 8) is loaded from `strap_sel1` when `strap_neg_en` is 0, and is loaded with 0 when `strap_neg_en` is 1.
- R3: Fiber mode (`strap_fx`=1). The duplex bit is loaded from `strap_sel0`, and `strap_neg_en` and `strap_sel1` are ignored. The auto-negotiation bit stays 0, and `fiber_mode` reads 1.
- R4: In half duplex (bit 8 = 0), `mii_crs` is `tx_active` OR `rx_active`.
- R5: In full duplex (bit 8 = 1), `mii_crs` equals `rx_active` whatever `tx_active` is.
- R6: In half duplex, `mii_col` equals `coll_raw`. In full duplex, `mii_col` is held at 0.
- R7: A write to address 0x00 updates bit 8 (duplex, 1 = full) and bit 12 (auto-negotiation) at the next clock edge. Reads of address 0x00 return those two bits and 0 in every other position. In fiber mode, a write to bit 12 is ignored.
- R8: Address 0x18 is the LED register, with NUM_LED=3. Bits [2:0] are override enables and bits [5:3] are override values. An LED with its enable set shows its value bit; any other LED follows `led_status`. Reads of 0x18 return 0.
- R9: For any other address, a read returns 0 and a write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fx | input | 1 | Fiber mode strap |
| strap_neg_en | input | 1 | Auto-negotiation enable strap |
| strap_sel1 | input | 1 | Forced-duplex strap (copper) |
| strap_sel0 | input | 1 | Duplex strap (fiber) |
| tx_active | input | 1 | Transmit activity from the datapath |
| rx_active | input | 1 | Receive activity from the datapath |
| coll_raw | input | 1 | Raw collision detect |
| led_status | input | NUM_LED | Default LED status sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| mii_crs | output | 1 | MII carrier sense |
| mii_col | output | 1 | MII collision |
| duplex_full | output | 1 | Current duplex bit |
| aneg_enable | output | 1 | Current auto-negotiation bit |
| fiber_mode | output | 1 | Latched fiber strap |
| led_out | output | NUM_LED | LED outputs |

## Verification
The assertions assume three things about the environment:
- The datapath indications and the register strobe are synchronous to `clk`.
- A register write is only meaningful after the straps have been captured.
- `led_status` changes only away from the clock edge.

The stimulus keeps to these assumptions. It changes every input at the falling edge and holds the strap pins steady through the release of reset. It also issues writes only after that first capture edge. Strap pins are then deliberately moved while the block runs, to show that the captured configuration does not change.

// File: rtl/phy_dx_pkg.sv
package phy_dx_pkg;
  localparam int ADDR_MODE = 'h00;
  localparam int ADDR_LED  = 'h18;
  localparam int BIT_DUPLEX = 8;
  localparam int BIT_ANEG   = 12;

  typedef struct packed {
    logic fx;
    logic neg_en;
    logic sel1;
    logic sel0;
  } strap_t;
endpackage

// File: rtl/phy_dx_strap.sv
module phy_dx_strap
  import phy_dx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t pins,
  output logic   load,
  output logic   done,
  output logic   seed_duplex,
  output logic   seed_aneg,
  output strap_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      held <= '0;
    end else if (!done) begin
      done <= 1'b1;
      held <= pins;
    end
  end

  assign load = !done;

  // fiber: duplex from sel0, negotiation forced off
  // copper: negotiation from neg_en, forced duplex from sel1
  always_comb begin
    if (pins.fx) begin
      seed_duplex = pins.sel0;
      seed_aneg   = 1'b0;
    end else begin
      seed_duplex = pins.neg_en ? 1'b0 : pins.sel1;
      seed_aneg   = pins.neg_en;
    end
  end
endmodule

// File: rtl/phy_dx_regs.sv
module phy_dx_regs
  import phy_dx_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int NUM_LED = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              seed_duplex,
  input  logic              seed_aneg,
  input  logic              fiber,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              duplex,
  output logic              aneg,
  output logic [NUM_LED-1:0] ovr_en,
  output logic [NUM_LED-1:0] ovr_val
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
  localparam logic [ADDR_W-1:0] A_LED  = ADDR_W'(ADDR_LED);

  logic hit_mode, hit_led;
  assign hit_mode = wr && !load && (addr == A_MODE);
  assign hit_led  = wr && !load && (addr == A_LED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duplex <= 1'b0;
      aneg   <= 1'b0;
    end else if (load) begin
      duplex <= seed_duplex;
      aneg   <= seed_aneg;
    end else if (hit_mode) begin
      duplex <= wdata[BIT_DUPLEX];
      aneg   <= fiber ? 1'b0 : wdata[BIT_ANEG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en  <= '0;
      ovr_val <= '0;
    end else if (hit_led) begin
      ovr_en  <= wdata[NUM_LED-1:0];
      ovr_val <= wdata[2*NUM_LED-1:NUM_LED];
    end
  end

  // LED register is write-only: reads of it fall to zero
  always_comb begin
    rdata = '0;
    if (addr == A_MODE) begin
      rdata[BIT_DUPLEX] = duplex;
      rdata[BIT_ANEG]   = aneg;
    end
  end
endmodule

// File: rtl/phy_dx_mii.sv
module phy_dx_mii (
  input  logic full,
  input  logic tx_active,
  input  logic rx_active,
  input  logic coll_raw,
  output logic crs,
  output logic col
);
  always_comb begin
    if (full) begin
      crs = rx_active;
      col = 1'b0;
    end else begin
      crs = tx_active | rx_active;
      col = coll_raw;
    end
  end
endmodule

// File: rtl/phy_dx_led.sv
module phy_dx_led #(
  parameter int NUM_LED = 3
) (
  input  logic [NUM_LED-1:0] status,
  input  logic [NUM_LED-1:0] ovr_en,
  input  logic [NUM_LED-1:0] ovr_val,
  output logic [NUM_LED-1:0] led
);
  for (genvar i = 0; i < NUM_LED; i++) begin : g_led
    assign led[i] = ovr_en[i] ? ovr_val[i] : status[i];
  end
endmodule

// File: rtl/phy_dx_ctrl.sv
module phy_dx_ctrl
  import phy_dx_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int NUM_LED = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_fx,
  input  logic               strap_neg_en,
  input  logic               strap_sel1,
  input  logic               strap_sel0,
  input  logic               tx_active,
  input  logic               rx_active,
  input  logic               coll_raw,
  input  logic [NUM_LED-1:0] led_status,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               mii_crs,
  output logic               mii_col,
  output logic               duplex_full,
  output logic               aneg_enable,
  output logic               fiber_mode,
  output logic [NUM_LED-1:0] led_out
);
  strap_t pins, held;
  logic   load, straps_held, seed_duplex, seed_aneg;
  logic [NUM_LED-1:0] led_ovr_en, led_ovr_val;

  assign pins = '{fx: strap_fx, neg_en: strap_neg_en, sel1: strap_sel1, sel0: strap_sel0};

  phy_dx_strap u_strap (
    .clk(clk), .rst_n(rst_n), .pins(pins), .load(load), .done(straps_held),
    .seed_duplex(seed_duplex), .seed_aneg(seed_aneg), .held(held)
  );

  assign fiber_mode = held.fx;

  phy_dx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LED(NUM_LED)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .seed_duplex(seed_duplex),
    .seed_aneg(seed_aneg), .fiber(held.fx), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .duplex(duplex_full),
    .aneg(aneg_enable), .ovr_en(led_ovr_en), .ovr_val(led_ovr_val)
  );

  phy_dx_mii u_mii (
    .full(duplex_full), .tx_active(tx_active), .rx_active(rx_active),
    .coll_raw(coll_raw), .crs(mii_crs), .col(mii_col)
  );

  phy_dx_led #(.NUM_LED(NUM_LED)) u_led (
    .status(led_status), .ovr_en(led_ovr_en), .ovr_val(led_ovr_val), .led(led_out)
  );
endmodule

// File: rtl/phy_dx_ctrl_chk.sv
module phy_dx_ctrl_chk #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int NUM_LED = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               straps_held,
  input logic               tx_active,
  input logic               rx_active,
  input logic               coll_raw,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               mii_crs,
  input logic               mii_col,
  input logic               duplex_full,
  input logic               aneg_enable,
  input logic               fiber_mode,
  input logic [NUM_LED-1:0] led_ovr_en,
  input logic [NUM_LED-1:0] led_status,
  input logic [NUM_LED-1:0] led_out
);
  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    straps_held |=> $stable(fiber_mode));
  assert_fiber_noneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiber_mode |-> !aneg_enable);
  assert_crs_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !duplex_full |-> (mii_crs == (tx_active | rx_active)));
  assert_crs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    duplex_full |-> (mii_crs == rx_active));
  assert_col_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    duplex_full |-> !mii_col);
  assert_col_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !duplex_full |-> (mii_col == coll_raw));
  assert_duplex_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (straps_held && reg_wr && reg_addr == '0) |=> (duplex_full == $past(reg_wdata[8])));
  assert_led_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (led_ovr_en == '0) |-> (led_out == led_status));
endmodule

bind phy_dx_ctrl phy_dx_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LED(NUM_LED)) u_chk (
  .clk(clk), .rst_n(rst_n), .straps_held(straps_held), .tx_active(tx_active),
  .rx_active(rx_active), .coll_raw(coll_raw), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mii_crs(mii_crs), .mii_col(mii_col),
  .duplex_full(duplex_full), .aneg_enable(aneg_enable), .fiber_mode(fiber_mode),
  .led_ovr_en(led_ovr_en), .led_status(led_status), .led_out(led_out)
);

// File: tb/phy_dx_ctrl_bench.sv
module phy_dx_ctrl_bench;
  localparam int AW = 5, DW = 16, NL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_fx = 0, strap_neg_en = 0, strap_sel1 = 0, strap_sel0 = 0;
  logic tx_active = 0, rx_active = 0, coll_raw = 0;
  logic [NL-1:0] led_status = '0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic mii_crs, mii_col, duplex_full, aneg_enable, fiber_mode;
  logic [NL-1:0] led_out;

  phy_dx_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_LED(NL)) u_phy_dx_ctrl (.*);

  always #10 clk = ~clk;

  typedef enum int {S_CRS, S_COL, S_RD, S_LED, S_DUP, S_ANEG, S_FX} sel_t;
  typedef struct {string req; sel_t sel; logic [DW-1:0] exp;} item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [DW-1:0] observe(sel_t s);
    case (s)
      S_CRS:  return DW'(mii_crs);
      S_COL:  return DW'(mii_col);
      S_RD:   return reg_rdata;
      S_LED:  return DW'(led_out);
      S_DUP:  return DW'(duplex_full);
      S_ANEG: return DW'(aneg_enable);
      default: return DW'(fiber_mode);
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial forever begin
    item_t it;
    logic [DW-1:0] act;
    wait (q.size() != 0);
    it = q.pop_front();
    act = observe(it.sel);
    n_chk++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
    end
  end

  task automatic expect_out(string req, sel_t s, logic [DW-1:0] e);
    #2;
    q.push_back('{req, s, e});
    #1;
  endtask

  task automatic do_reset(logic fx, logic en, logic s1, logic s0);
    @(negedge clk);
    rst_n = 0; reg_wr = 0;
    strap_fx = fx; strap_neg_en = en; strap_sel1 = s1; strap_sel0 = s0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [DW-1:0] e);
    reg_addr = a;
    expect_out(req, S_RD, e);
  endtask

  task automatic drive(logic t, logic r, logic c);
    @(negedge clk);
    tx_active = t; rx_active = r; coll_raw = c;
  endtask

  initial begin
    // R2: copper, negotiation on -> duplex 0, aneg 1
    do_reset(0, 1, 1, 1);
    expect_out("R2", S_ANEG, 1);
    expect_out("R2", S_DUP, 0);
    expect_out("R3", S_FX, 0);
    rd("R7", 5'h00, 16'h1000);
    // R1: strap changes after capture do nothing
    @(negedge clk);
    strap_fx = 1; strap_neg_en = 0; strap_sel0 = 1;
    repeat (2) @(negedge clk);
    rd("R1", 5'h00, 16'h1000);
    expect_out("R1", S_FX, 0);
    // R4 / R6 half duplex
    drive(1, 0, 0); expect_out("R4", S_CRS, 1);
    drive(0, 1, 0); expect_out("R4", S_CRS, 1);
    drive(0, 0, 0); expect_out("R4", S_CRS, 0);
    drive(1, 1, 1); expect_out("R6", S_COL, 1);
    drive(0, 0, 0); expect_out("R6", S_COL, 0);
    // R7: software sets full duplex
    wr(5'h00, 16'h0100);
    expect_out("R7", S_DUP, 1);
    rd("R7", 5'h00, 16'h0100);
    // R5 / R6 full duplex
    drive(1, 0, 1); expect_out("R5", S_CRS, 0);
    expect_out("R6", S_COL, 0);
    drive(1, 1, 1); expect_out("R5", S_CRS, 1);
    expect_out("R6", S_COL, 0);
    drive(0, 0, 0);
    // R9 unknown address
    wr(5'h05, 16'hFFFF);
    rd("R9", 5'h05, 16'h0000);
    rd("R9", 5'h00, 16'h0100);
    // R8 LED override
    @(negedge clk); led_status = 3'b110;
    expect_out("R8", S_LED, 16'h0006);
    wr(5'h18, 16'h000D);
    expect_out("R8", S_LED, 16'h0003);
    rd("R8", 5'h18, 16'h0000);
    wr(5'h18, 16'h0000);
    expect_out("R8", S_LED, 16'h0006);
    // R2: copper forced, sel1 = 1 -> full
    do_reset(0, 0, 1, 0);
    expect_out("R2", S_DUP, 1);
    expect_out("R2", S_ANEG, 0);
    // R3: fiber, sel0 seeds duplex, neg_en ignored
    do_reset(1, 1, 0, 1);
    expect_out("R3", S_DUP, 1);
    expect_out("R3", S_ANEG, 0);
    expect_out("R3", S_FX, 1);
    do_reset(1, 1, 1, 0);
    expect_out("R3", S_DUP, 0);
    // R7: negotiation write ignored in fiber
    wr(5'h00, 16'h1000);
    rd("R7", 5'h00, 16'h0000);
    repeat (2) @(negedge clk);
    wait (q.size() == 0);
    #1;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule